// File: doc/BRIEF.md
# Priority Pin Crossbar Decoder

This block routes the digital signals of a fixed set of on-chip peripherals onto 24 general-purpose pins, grouped as three 8-bit ports. Pin positions are not fixed. Each enabled peripheral is visited in a fixed priority order, and it takes the lowest-numbered pins that are still free and not skipped. Enabling a high-priority peripheral therefore moves the pins of every peripheral below it. A pin that is skipped, or that no enabled peripheral claims, falls back to GPIO and is driven from a port latch register. The last pin, port 2 bit 7, never takes part in the assignment and always acts as GPIO.

Software sets up the block through a write-only register interface. It writes the peripheral enables, the number of timer-capture channels, a global crossbar enable, one skip mask per port and one output latch per port. The assignment is purely combinational from these registers. Peripheral output values and output enables reach their pins, and pin levels return to the peripheral inputs that own them. When the pins run out, the remaining signals are left unconnected and a per-peripheral overflow flag is raised.

Top module: `prio_xbar`

## Requirements
- R1: After reset all peripheral enables are clear, the capture-channel count is 0, the global enable is off, every skip bit is 0 and every latch bit is 1. As a result, all `pin_oe` and `pin_out` bits are 0, all `per_in` bits are 1 and `per_ovf` is 0.
- R2: A register takes `cfg_wdata` on a rising `clk` edge while `cfg_we` is high and is seen at the outputs from the following cycle. The register map is:
  - address 0: enables. Bit0 serial port, bit1 wide SPI, bit2 narrow SPI, bit3 two-wire bus, bit4 comparator 0, bit5 comparator 1, bit6 clock out, bit7 timer inputs.
  - address 1: control. Bits[2:0] give the capture-channel count and bit7 is the global enable.
  - addresses 2 to 4: skip masks for ports 0 to 2.
  - addresses 5 to 7: latches for ports 0 to 2.
  - A write to any other address changes nothing.
- R3: Signals are claimed in a fixed order. The slots are, by index:
  - serial TX 0 and RX 1;
  - wide SPI SCK 2, MISO 3, MOSI 4 and NSS 5;
  - narrow SPI SCK 6 and MOSI 7;
  - two-wire SDA 8 and SCL 9;
  - comparator 0 at 10, comparator 1 at 11 and clock out at 12;
  - capture channels 0 to 6 at 13 to 19;
  - timer 0 at 20 and timer 1 at 21.
- R4: Pins are visited upward from pin 0 (port 0 bit 0; pin n is port n/8 bit n%8). Each enabled slot, in slot order, takes the next unskipped pin that no earlier slot holds. Pin 23 is never assigned.
- R5: A pin whose skip bit is set is never claimed and behaves as GPIO.
- R6: While the global enable is set, an unclaimed pin (including pin 23) drives `pin_out` = latch bit and `pin_oe` = inverted latch bit.
- R7: A claimed pin copies the owning slot's `per_out` and `per_oe` bits, and that slot's `per_in` bit equals the pin's `pin_in` level. A slot with no pin reads 1.
- R8: An enabled slot that finds no free pin sets the `per_ovf` bit of its peripheral. The bit order is bit0 serial, 1 wide SPI, 2 narrow SPI, 3 two-wire, 4 comparator 0, 5 comparator 1, 6 clock out, 7 capture, 8 timers.
- R9: While the global enable is clear, all `pin_oe` and `pin_out` bits are 0, all `per_in` bits are 1 and `per_ovf` is 0, whatever the enables are.
- R10: A capture-channel count of k enables channels 0 to k-1 only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_we | input | 1 | Write strobe |
| per_out | input | 22 | Peripheral output value per slot |
| per_oe | input | 22 | Peripheral output enable per slot |
| pin_in | input | 24 | Pin input levels |
| pin_out | output | 24 | Pin drive values |
| pin_oe | output | 24 | Pin driver enables |
| per_in | output | 22 | Routed input per slot |
| per_ovf | output | 9 | Per-peripheral overflow flags |

## Verification
The bench uses the package defaults: three 8-bit ports and seven capture channels, which gives 22 slots competing for 23 crossbar pins. With every peripheral enabled, one pin is therefore left over. Overflow can only be reached when skip masks remove pins, so the bench writes dense skip masks to drive the overflow flags and the truncated lower-priority peripherals. Sparse random skip masks move every claimed position, and the capture-channel count sweeps the full 0 to 7 range.

// File: rtl/prio_xbar_pkg.sv
package prio_xbar_pkg;
    localparam int PORT_W    = 8;
    localparam int NUM_PORTS = 3;
    localparam int NPINS     = PORT_W * NUM_PORTS;
    localparam int XPINS     = NPINS - 1;
    localparam int PCA_MAX   = 7;
    localparam int PCA_CW    = $clog2(PCA_MAX + 1);
    localparam int EN_W      = 8;
    localparam int CFG_AW    = 4;
    localparam int CFG_DW    = PORT_W;

    localparam int UART_N = 2;
    localparam int SPIA_N = 4;
    localparam int SPIB_N = 2;
    localparam int SMB_N  = 2;
    localparam int TMR_N  = 2;

    localparam int UART_B = 0;
    localparam int SPIA_B = UART_B + UART_N;
    localparam int SPIB_B = SPIA_B + SPIA_N;
    localparam int SMB_B  = SPIB_B + SPIB_N;
    localparam int CMP0_B = SMB_B + SMB_N;
    localparam int CMP1_B = CMP0_B + 1;
    localparam int CLKO_B = CMP1_B + 1;
    localparam int PCA_B  = CLKO_B + 1;
    localparam int TMR_B  = PCA_B + PCA_MAX;
    localparam int NSLOT  = TMR_B + TMR_N;

    localparam int SLOT_W = $clog2(NSLOT);
    localparam int PIN_W  = $clog2(NPINS);
    localparam int CNT_W  = $clog2(NPINS + 1);

    localparam int ADDR_EN     = 0;
    localparam int ADDR_CTL    = 1;
    localparam int ADDR_SKIP0  = 2;
    localparam int ADDR_LATCH0 = ADDR_SKIP0 + NUM_PORTS;

    typedef enum logic [3:0] {
        PID_UART, PID_SPIA, PID_SPIB, PID_SMB, PID_CMP0,
        PID_CMP1, PID_CLKO, PID_PCA, PID_TMR
    } periph_e;
    localparam int NPERIPH = 9;

    function automatic periph_e periph_of(int s);
        if (s < SPIA_B)      return PID_UART;
        else if (s < SPIB_B) return PID_SPIA;
        else if (s < SMB_B)  return PID_SPIB;
        else if (s < CMP0_B) return PID_SMB;
        else if (s < CMP1_B) return PID_CMP0;
        else if (s < CLKO_B) return PID_CMP1;
        else if (s < PCA_B)  return PID_CLKO;
        else if (s < TMR_B)  return PID_PCA;
        else                 return PID_TMR;
    endfunction
endpackage

// File: rtl/prio_xbar_regs.sv
module prio_xbar_regs
    import prio_xbar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              cfg_we,
    output logic [EN_W-1:0]   per_en,
    output logic [PCA_CW-1:0] pca_cnt,
    output logic              xen,
    output logic [NPINS-1:0]  skip,
    output logic [NPINS-1:0]  latch
);
    logic wdata_unused;
    assign wdata_unused = ^cfg_wdata[CFG_DW-2:PCA_CW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_en  <= '0;
            pca_cnt <= '0;
            xen     <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_addr == CFG_AW'(ADDR_EN))
                per_en <= cfg_wdata;
            if (cfg_addr == CFG_AW'(ADDR_CTL)) begin
                pca_cnt <= cfg_wdata[PCA_CW-1:0];
                xen     <= cfg_wdata[CFG_DW-1];
            end
        end
    end

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        logic [PORT_W-1:0] skip_q;
        logic [PORT_W-1:0] latch_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                skip_q  <= '0;
                latch_q <= '1;
            end else if (cfg_we) begin
                if (cfg_addr == CFG_AW'(ADDR_SKIP0 + i))
                    skip_q <= cfg_wdata;
                if (cfg_addr == CFG_AW'(ADDR_LATCH0 + i))
                    latch_q <= cfg_wdata;
            end
        end
        assign skip[i*PORT_W +: PORT_W]  = skip_q;
        assign latch[i*PORT_W +: PORT_W] = latch_q;
    end
endmodule

// File: rtl/prio_xbar_assign.sv
module prio_xbar_assign
    import prio_xbar_pkg::*;
(
    input  logic                          xen,
    input  logic [EN_W-1:0]               per_en,
    input  logic [PCA_CW-1:0]             pca_cnt,
    input  logic [XPINS-1:0]              skip,
    output logic [XPINS-1:0]              pin_hit,
    output logic [XPINS-1:0][SLOT_W-1:0]  pin_sel,
    output logic [NSLOT-1:0]              slot_hit,
    output logic [NSLOT-1:0][PIN_W-1:0]   slot_pin,
    output logic [NPERIPH-1:0]            per_ovf
);
    logic [NSLOT-1:0]            slot_en;
    logic [NSLOT-1:0][CNT_W-1:0] rank;
    logic [XPINS-1:0][CNT_W-1:0] fidx;
    logic [CNT_W-1:0]            scnt;
    logic [CNT_W-1:0]            pcnt;
    periph_e                     pid;

    // which slots are requested
    always_comb begin
        slot_en = '0;
        pid     = PID_UART;
        for (int s = 0; s < NSLOT; s++) begin
            pid = periph_of(s);
            if (pid == PID_PCA)
                slot_en[s] = (s - PCA_B) < int'(pca_cnt);
            else if (pid == PID_TMR)
                slot_en[s] = per_en[EN_W-1];
            else
                slot_en[s] = per_en[pid[2:0]];
        end
    end

    // rank of each requested slot, index of each free pin
    always_comb begin
        scnt = '0;
        for (int s = 0; s < NSLOT; s++) begin
            rank[s] = scnt;
            if (slot_en[s]) scnt = scnt + CNT_W'(1);
        end
        pcnt = '0;
        for (int p = 0; p < XPINS; p++) begin
            fidx[p] = pcnt;
            if (!skip[p]) pcnt = pcnt + CNT_W'(1);
        end
    end

    // the n-th requested slot meets the n-th free pin
    always_comb begin
        pin_hit  = '0;
        pin_sel  = '0;
        slot_hit = '0;
        slot_pin = '0;
        for (int p = 0; p < XPINS; p++) begin
            for (int s = 0; s < NSLOT; s++) begin
                if (xen && slot_en[s] && !skip[p] && rank[s] == fidx[p]) begin
                    pin_hit[p]  = 1'b1;
                    pin_sel[p]  = SLOT_W'(s);
                    slot_hit[s] = 1'b1;
                    slot_pin[s] = PIN_W'(p);
                end
            end
        end
    end

    always_comb begin
        per_ovf = '0;
        for (int s = 0; s < NSLOT; s++)
            if (xen && slot_en[s] && !slot_hit[s])
                per_ovf[periph_of(s)] = 1'b1;
    end
endmodule

// File: rtl/prio_xbar_pinmux.sv
module prio_xbar_pinmux
    import prio_xbar_pkg::*;
(
    input  logic                         xen,
    input  logic [NPINS-1:0]             latch,
    input  logic [XPINS-1:0]             pin_hit,
    input  logic [XPINS-1:0][SLOT_W-1:0] pin_sel,
    input  logic [NSLOT-1:0]             slot_hit,
    input  logic [NSLOT-1:0][PIN_W-1:0]  slot_pin,
    input  logic [NSLOT-1:0]             per_out,
    input  logic [NSLOT-1:0]             per_oe,
    input  logic [NPINS-1:0]             pin_in,
    output logic [NPINS-1:0]             pin_out,
    output logic [NPINS-1:0]             pin_oe,
    output logic [NSLOT-1:0]             per_in
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        if (p < XPINS) begin : g_xbar
            assign pin_out[p] = xen & (pin_hit[p] ? per_out[pin_sel[p]] : latch[p]);
            assign pin_oe[p]  = xen & (pin_hit[p] ? per_oe[pin_sel[p]]  : ~latch[p]);
        end else begin : g_spare
            assign pin_out[p] = xen & latch[p];
            assign pin_oe[p]  = xen & ~latch[p];
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign per_in[s] = slot_hit[s] ? pin_in[slot_pin[s]] : 1'b1;
    end
endmodule

// File: rtl/prio_xbar.sv
module prio_xbar
    import prio_xbar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              cfg_we,
    input  logic [NSLOT-1:0]  per_out,
    input  logic [NSLOT-1:0]  per_oe,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NSLOT-1:0]  per_in,
    output logic [NPERIPH-1:0] per_ovf
);
    logic [EN_W-1:0]              per_en;
    logic [PCA_CW-1:0]            pca_cnt;
    logic                         xen;
    logic [NPINS-1:0]             skip;
    logic [NPINS-1:0]             latch;
    logic [XPINS-1:0]             pin_hit;
    logic [XPINS-1:0][SLOT_W-1:0] pin_sel;
    logic [NSLOT-1:0]             slot_hit;
    logic [NSLOT-1:0][PIN_W-1:0]  slot_pin;

    prio_xbar_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_we(cfg_we), .per_en(per_en), .pca_cnt(pca_cnt), .xen(xen),
        .skip(skip), .latch(latch)
    );

    prio_xbar_assign u_assign (
        .xen(xen), .per_en(per_en), .pca_cnt(pca_cnt), .skip(skip[XPINS-1:0]),
        .pin_hit(pin_hit), .pin_sel(pin_sel), .slot_hit(slot_hit),
        .slot_pin(slot_pin), .per_ovf(per_ovf)
    );

    prio_xbar_pinmux u_pinmux (
        .xen(xen), .latch(latch), .pin_hit(pin_hit), .pin_sel(pin_sel),
        .slot_hit(slot_hit), .slot_pin(slot_pin), .per_out(per_out),
        .per_oe(per_oe), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .per_in(per_in)
    );

    logic skip_unused;
    assign skip_unused = skip[NPINS-1];
endmodule

// File: rtl/prio_xbar_chk.sv
module prio_xbar_chk
    import prio_xbar_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [CFG_DW-1:0] cfg_wdata,
    input logic              cfg_we,
    input logic              xen,
    input logic [NPINS-1:0]  skip,
    input logic [NPINS-1:0]  latch,
    input logic [XPINS-1:0]  pin_hit,
    input logic [NSLOT-1:0]  slot_hit,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NSLOT-1:0]  per_in,
    input logic [NPERIPH-1:0] per_ovf
);
    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !xen |-> (pin_oe == '0 && per_in == '1 && per_ovf == '0));

    assert_skip_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_hit & skip[XPINS-1:0]) == '0);

    assert_one_to_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pin_hit) == $countones(slot_hit));

    assert_ovf_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|per_ovf) |-> (pin_hit == ~skip[XPINS-1:0]));

    assert_skip_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == CFG_AW'(ADDR_SKIP0)) |=> (skip[PORT_W-1:0] == $past(cfg_wdata)));

    assert_spare_gpio_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xen |-> (pin_oe[NPINS-1] == ~latch[NPINS-1]));
endmodule

bind prio_xbar prio_xbar_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_we(cfg_we), .xen(xen), .skip(skip), .latch(latch), .pin_hit(pin_hit),
    .slot_hit(slot_hit), .pin_oe(pin_oe), .per_in(per_in), .per_ovf(per_ovf)
);

// File: tb/prio_xbar_test.sv
`timescale 1ns/1ps
module prio_xbar_test;
    import prio_xbar_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n;
    logic [CFG_AW-1:0] cfg_addr;
    logic [CFG_DW-1:0] cfg_wdata;
    logic              cfg_we;
    logic [NSLOT-1:0]  per_out, per_oe, per_in;
    logic [NPINS-1:0]  pin_in, pin_out, pin_oe;
    logic [NPERIPH-1:0] per_ovf;

    prio_xbar uut (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_we(cfg_we), .per_out(per_out), .per_oe(per_oe), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .per_in(per_in), .per_ovf(per_ovf)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0]       m_en;
    logic [2:0]       m_pca;
    logic             m_xen;
    logic [NPINS-1:0] m_skip, m_latch;

    function automatic int pid(int s);
        if (s < 2) return 0;
        if (s < 6) return 1;
        if (s < 8) return 2;
        if (s < 10) return 3;
        if (s == 10) return 4;
        if (s == 11) return 5;
        if (s == 12) return 6;
        if (s < 20) return 7;
        return 8;
    endfunction

    function automatic bit sen(int s);
        int k = pid(s);
        if (k < 7) return m_en[k];
        if (k == 7) return (s - 13) < int'(m_pca);
        return m_en[7];
    endfunction

    // reference: walk pins upward, hand each free pin to the next requested slot
    task automatic model(output logic [NPINS-1:0] eo, output logic [NPINS-1:0] eoe,
                         output logic [NSLOT-1:0] ei, output logic [NPERIPH-1:0] ev);
        eo = '0; eoe = '0; ei = '1; ev = '0;
        if (m_xen) begin
            int s;
            s = 0;
            for (int p = 0; p < NPINS; p++) begin
                eo[p] = m_latch[p];
                eoe[p] = ~m_latch[p];
                if (p != NPINS - 1 && !m_skip[p]) begin
                    while (s < NSLOT && !sen(s)) s++;
                    if (s < NSLOT) begin
                        eo[p] = per_out[s];
                        eoe[p] = per_oe[s];
                        ei[s] = pin_in[p];
                        s++;
                    end
                end
            end
            while (s < NSLOT) begin
                if (sen(s)) ev[pid(s)] = 1'b1;
                s++;
            end
        end
    endtask

    task automatic cmp(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        cfg_addr = CFG_AW'(a); cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            0: m_en = d;
            1: begin m_pca = d[2:0]; m_xen = d[7]; end
            2, 3, 4: m_skip[(a-2)*8 +: 8] = d;
            5, 6, 7: m_latch[(a-5)*8 +: 8] = d;
            default: ;
        endcase
    endtask

    task automatic stim();
        per_out = NSLOT'($urandom);
        per_oe  = NSLOT'($urandom);
        pin_in  = NPINS'($urandom);
    endtask

    task automatic chk(input string r);
        logic [NPINS-1:0] eo, eoe;
        logic [NSLOT-1:0] ei;
        logic [NPERIPH-1:0] ev;
        #1;
        model(eo, eoe, ei, ev);
        cmp(r, "pin_out", 32'(pin_out), 32'(eo));
        cmp(r, "pin_oe", 32'(pin_oe), 32'(eoe));
        cmp(r, "per_in", 32'(per_in), 32'(ei));
        cmp(r, "per_ovf", 32'(per_ovf), 32'(ev));
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog R1: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        per_out = '0; per_oe = '0; pin_in = '0;
        m_en = '0; m_pca = '0; m_xen = 1'b0; m_skip = '0; m_latch = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        stim(); chk("R1");
        cmp("R1", "pin_oe reset", 32'(pin_oe), 32'h0);
        cmp("R1", "per_in reset", 32'(per_in), 32'(22'h3FFFFF));
        wr(0, 8'hFF); wr(1, 8'h07); stim(); chk("R9");
        wr(1, 8'h80); wr(0, 8'h01); stim(); chk("R3");
        per_out = 22'h000001; per_oe = 22'h000001; #1;
        cmp("R3", "uart tx on pin0", 32'(pin_out[0] & pin_oe[0]), 32'h1);
        wr(0, 8'h03); stim(); chk("R3");
        wr(0, 8'h02); per_out = 22'h000004; per_oe = 22'h000004; #1;
        cmp("R4", "spi sck moves to pin0", 32'(pin_out[0] & pin_oe[0]), 32'h1);
        stim(); chk("R4");
        wr(0, 8'hFF); wr(1, 8'h87); stim(); chk("R10");
        wr(1, 8'h83); stim(); chk("R10");
        wr(2, 8'hF0); wr(3, 8'h0F); stim(); chk("R5");
        wr(1, 8'h87); wr(2, 8'hFF); wr(3, 8'hFF); wr(4, 8'h3C); stim(); chk("R8");
        cmp("R8", "overflow flags", 32'(per_ovf), 32'h1FE);
        wr(5, 8'hA5); wr(6, 8'h3C); wr(7, 8'h5A); stim(); chk("R6");
        wr(15, 8'h00); stim(); chk("R2");
        for (int i = 0; i < 500; i++) begin
            int a;
            logic [7:0] d;
            a = $urandom_range(0, 8);
            d = 8'($urandom);
            if (a >= 2 && a <= 4) d = d & 8'($urandom) & 8'($urandom);
            if (a == 1) d[7] = ($urandom_range(0, 9) != 0);
            wr(a, d);
            stim(); chk("R7");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule